// File: doc/BRIEF.md
# Scan-Testable Muller C-Element Chain

A row of `N_CELLS` C-element storage cells. Each cell has a pair of functional inputs and holds one state bit. The bit sets when the cell's set function is true, clears when its clear function is true, and otherwise keeps its value. For the default symmetric kind, set is `a AND b` and clear is `NOT a AND NOT b`. An asymmetric kind is available as a parameter; its clear term depends on `a` alone.

In normal operation the chain runs in transparent mode. Each cell then behaves as a plain asynchronous C-element, and the test clocks have no effect.

For test, two non-overlapping clock phases drive every cell. Each cell holds its bit in a master/slave latch pair: the master is open on `phi1` and the slave is open on `phi2`. With `scan_en` high, the cells link into one serial register from `scan_in` to `scan_out`. With `scan_en` low, each cell captures its own functional next state.

An active-low reset clears every cell in every mode, so the starting state is known.

Top module: `msc_chain`

## Requirements
- R1: With `test_mode`=0, a cell whose set function is true (symmetric kind: `in_a[i]`=1 and `in_b[i]`=1) drives `state[i]`=1 without any clock phase.
- R2: With `test_mode`=0, a cell whose clear function is true (symmetric kind: `in_a[i]`=0 and `in_b[i]`=0) drives `state[i]`=0 without any clock phase.
- R3: With `test_mode`=0, a cell whose inputs disagree keeps its previous `state[i]`.
- R4: With `test_mode`=0, pulses on `phi1`/`phi2` and any value on `scan_en` and `scan_in` leave `state` unchanged.
- R5: With `test_mode`=1 and `scan_en`=1, each `phi1` pulse followed by a `phi2` pulse moves the chain one place: `state[0]` takes `scan_in`, `state[i]` takes the old `state[i-1]`, and the values of `in_a`/`in_b` do not matter. The two phases are never high together.
- R6: `scan_out` always equals `state[N_CELLS-1]`. After `N_CELLS` shift pairs the chain holds the shifted-in word, and a second `N_CELLS` shifts present that word on `scan_out`, most significant bit first.
- R7: With `test_mode`=1 and `scan_en`=0, one `phi1`/`phi2` pair loads each cell with its functional next state. For the symmetric kind that is `(a&b) | (old & (a|b))`.
- R8: With `test_mode`=1, `state` changes only during a `phi2` pulse. An input change, or a `phi1` pulse on its own, leaves `state` unchanged.
- R9: While `rst_n`=0, every bit of `state` is 0, whatever the mode and clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| phi1 | input | 1 | Test clock phase 1; opens master latches |
| phi2 | input | 1 | Test clock phase 2; opens slave latches |
| rst_n | input | 1 | Active-low reset, clears all cells |
| test_mode | input | 1 | 0 = transparent, 1 = clocked test |
| scan_en | input | 1 | In test mode: 1 = shift, 0 = capture |
| scan_in | input | 1 | Serial data into cell 0 |
| in_a | input | N_CELLS | First functional input of each cell |
| in_b | input | N_CELLS | Second functional input of each cell |
| state | output | N_CELLS | Stored bit of each cell |
| scan_out | output | 1 | Serial data out of the last cell |

## Verification
The transparent test applies a sequence of input words. Within that sequence some bit lanes agree high, some agree low and some disagree, so set, clear and hold show up side by side and a swapped or stuck term is exposed.

Shift tests use two asymmetric words, one going in and one coming out. A reversed chain, a skipped stage or a missing phase then produces a different bit order.

Capture patterns mix set, clear and hold lanes over a preloaded state. Checks placed between the input change, the `phi1` pulse and the `phi2` pulse show whether a latch opens in the wrong phase.

// File: rtl/msc_pkg.sv
// Package: shared types for the scannable C-element chain.
// Assumes: nothing beyond IEEE 1800-2017.
package msc_pkg;

    // Choice of set/clear functions for every cell of a chain.
    typedef enum logic {
        CE_SYM  = 1'b0,   // set = a&b, clear = ~a&~b
        CE_ASYM = 1'b1    // set = a&b, clear = ~a
    } ce_kind_e;

endpackage

// File: rtl/msc_mode_dec.sv
// Module: decodes the two mode pins into one-hot operating modes.
// Assumes: test_mode and scan_en are stable while a clock phase is high.
module msc_mode_dec (
    input  logic test_mode,
    input  logic scan_en,
    output logic transp,
    output logic shift,
    output logic capt
);

    // Purpose: map the pins onto transparent / shift / capture.
    always_comb begin
        transp = !test_mode;
        shift  = test_mode && scan_en;
        capt   = test_mode && !scan_en;
    end

endmodule

// File: rtl/msc_func.sv
// Module: set and clear functions of one C-element, selected by KIND.
// Assumes: the chosen functions are never true together.
module msc_func
    import msc_pkg::*;
#(
    parameter ce_kind_e KIND = CE_SYM
) (
    input  logic fa,
    input  logic fb,
    output logic set_f,
    output logic clr_f
);

    generate
        if (KIND == CE_SYM) begin : g_sym
            // Purpose: symmetric C-element, both inputs must agree.
            always_comb begin
                set_f = fa && fb;
                clr_f = !fa && !fb;
            end
        end else begin : g_asym
            // Purpose: asymmetric variant, clear driven by fa alone.
            always_comb begin
                set_f = fa && fb;
                clr_f = !fa;
            end
        end
    endgenerate

endmodule

// File: rtl/msc_cell.sv
// Module: one scan-testable C-element built from a master/slave latch pair.
// The master is open on phi1 and the slave on phi2; the slave output is the
// cell state. In transparent mode the slave acts as a bare C-element.
// Assumes: phi1 and phi2 never overlap; mode pins and functional inputs are
// stable from phi1 rising to phi2 falling in capture mode.
module msc_cell
    import msc_pkg::*;
#(
    parameter ce_kind_e KIND = CE_SYM
) (
    input  logic rst_n,
    input  logic phi1,
    input  logic phi2,
    input  logic transp,
    input  logic shift,
    input  logic capt,
    input  logic sin,
    input  logic fa,
    input  logic fb,
    output logic q
);

    logic set_f;
    logic clr_f;
    logic load;
    logic mst;

    msc_func #(.KIND(KIND)) u_func (
        .fa    (fa),
        .fb    (fb),
        .set_f (set_f),
        .clr_f (clr_f)
    );

    // Purpose: a clocked load happens on shift, or on capture when not holding.
    always_comb begin
        load = shift || (capt && (set_f || clr_f));
    end

    // Purpose: master latch, open on phi1, picks scan data or next state.
    always_latch begin
        if (!rst_n) begin
            mst <= 1'b0;
        end else if (phi1 && load) begin
            mst <= shift ? sin : set_f;
        end
    end

    // Purpose: slave latch, a C-element when transparent, phi2 copy otherwise.
    always_latch begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (transp) begin
            if (set_f) begin
                q <= 1'b1;
            end else if (clr_f) begin
                q <= 1'b0;
            end
        end else if (phi2 && load) begin
            q <= mst;
        end
    end

endmodule

// File: rtl/msc_chain.sv
// Module: top of the scannable C-element chain. Links N_CELLS cells so that
// cell i takes its serial input from cell i-1 and cell 0 from scan_in.
// Assumes: phi1/phi2 are two non-overlapping phases of the test clock.
module msc_chain
    import msc_pkg::*;
#(
    parameter int       N_CELLS = 8,
    parameter ce_kind_e KIND    = CE_SYM
) (
    input  logic               phi1,
    input  logic               phi2,
    input  logic               rst_n,
    input  logic               test_mode,
    input  logic               scan_en,
    input  logic               scan_in,
    input  logic [N_CELLS-1:0] in_a,
    input  logic [N_CELLS-1:0] in_b,
    output logic [N_CELLS-1:0] state,
    output logic               scan_out
);

    localparam int LAST = N_CELLS - 1;

    logic transp;
    logic shift;
    logic capt;

    msc_mode_dec u_mode (
        .test_mode (test_mode),
        .scan_en   (scan_en),
        .transp    (transp),
        .shift     (shift),
        .capt      (capt)
    );

    generate
        for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
            logic q_s;
            logic sin_s;

            if (i == 0) begin : g_head
                // Purpose: the first cell reads the external serial input.
                assign sin_s = scan_in;
            end else begin : g_link
                // Purpose: every later cell reads its predecessor.
                assign sin_s = g_cell[i-1].q_s;
            end

            msc_cell #(.KIND(KIND)) u_cell (
                .rst_n  (rst_n),
                .phi1   (phi1),
                .phi2   (phi2),
                .transp (transp),
                .shift  (shift),
                .capt   (capt),
                .sin    (sin_s),
                .fa     (in_a[i]),
                .fb     (in_b[i]),
                .q      (q_s)
            );

            // Purpose: expose the cell state on the output bus.
            assign state[i] = q_s;
        end
    endgenerate

    // Purpose: the serial output is the last stage of the chain.
    assign scan_out = g_cell[LAST].q_s;

endmodule

// File: rtl/msc_chain_chk.sv
// Checker: properties of msc_chain, bound to every instance of it.
module msc_chain_chk
    import msc_pkg::*;
#(
    parameter int       N_CELLS = 8,
    parameter ce_kind_e KIND    = CE_SYM
) (
    input logic               phi1,
    input logic               phi2,
    input logic               rst_n,
    input logic               test_mode,
    input logic               scan_en,
    input logic               scan_in,
    input logic [N_CELLS-1:0] in_a,
    input logic [N_CELLS-1:0] in_b,
    input logic [N_CELLS-1:0] state,
    input logic               scan_out
);

    AST_PHASE1_APART: assert property (@(posedge phi1) disable iff (!rst_n)
        !phi2);  // R5
    AST_PHASE2_APART: assert property (@(posedge phi2) disable iff (!rst_n)
        !phi1);  // R5
    AST_RESET_CLEAR: assert property (@(negedge phi1)
        !rst_n |-> state == '0);  // R9
    AST_SOUT_LAST: assert property (@(negedge phi1) disable iff (!rst_n)
        scan_out == state[N_CELLS-1]);  // R6

    generate
        if (N_CELLS > 1) begin : g_shift_chk
            AST_SHIFT_MOVE: assert property (@(negedge phi2) disable iff (!rst_n)
                (test_mode && scan_en && $past(test_mode && scan_en))
                |-> state[N_CELLS-1:1] == $past(state[N_CELLS-2:0]));  // R5
        end
        if (KIND == CE_SYM) begin : g_sym_chk
            AST_TRANSP_SET: assert property (@(negedge phi1) disable iff (!rst_n)
                !test_mode |-> ((in_a & in_b) & ~state) == '0);  // R1
            AST_TRANSP_CLR: assert property (@(negedge phi1) disable iff (!rst_n)
                !test_mode |-> ((~in_a & ~in_b) & state) == '0);  // R2
            AST_CAPTURE_NEXT: assert property (@(negedge phi2) disable iff (!rst_n)
                (test_mode && !scan_en && $past(test_mode && !scan_en)
                 && in_a == $past(in_a) && in_b == $past(in_b))
                |-> state == ((in_a & in_b) | ($past(state) & (in_a | in_b))));  // R7
        end
    endgenerate

endmodule

bind msc_chain msc_chain_chk #(.N_CELLS(N_CELLS), .KIND(KIND)) u_chk (
    .phi1      (phi1),
    .phi2      (phi2),
    .rst_n     (rst_n),
    .test_mode (test_mode),
    .scan_en   (scan_en),
    .scan_in   (scan_in),
    .in_a      (in_a),
    .in_b      (in_b),
    .state     (state),
    .scan_out  (scan_out)
);

// File: tb/sim_msc_chain.sv
// Bench: self-checking test of msc_chain; phases from a 50 MHz cycle.
module sim_msc_chain;
    import msc_pkg::*;

    localparam int N = 8;

    logic         phi1 = 1'b0;
    logic         phi2 = 1'b0;
    logic         rst_n = 1'b0;
    logic         test_mode = 1'b0;
    logic         scan_en = 1'b0;
    logic         scan_in = 1'b0;
    logic [N-1:0] in_a = '0;
    logic [N-1:0] in_b = '0;
    logic [N-1:0] state;
    logic         scan_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    msc_chain #(.N_CELLS(N), .KIND(CE_SYM)) u0 (
        .phi1      (phi1),
        .phi2      (phi2),
        .rst_n     (rst_n),
        .test_mode (test_mode),
        .scan_en   (scan_en),
        .scan_in   (scan_in),
        .in_a      (in_a),
        .in_b      (in_b),
        .state     (state),
        .scan_out  (scan_out)
    );

    // 20 ns cycle: phi1 high 0-5, phi2 high 10-15.
    initial begin
        forever begin
            phi1 = 1'b1; #5;
            phi1 = 1'b0; #5;
            phi2 = 1'b1; #5;
            phi2 = 1'b0; #5;
        end
    end

    // Transparent vectors {a, b, expected state}, applied in order from state 0.
    localparam logic [3*N-1:0] TV [8] = '{
        {8'hFF, 8'h00, 8'h00},
        {8'hF0, 8'hF0, 8'hF0},
        {8'h0F, 8'h0F, 8'h0F},
        {8'h3C, 8'h00, 8'h0C},
        {8'hFF, 8'hFF, 8'hFF},
        {8'hAA, 8'h55, 8'hFF},
        {8'h00, 8'hF0, 8'hF0},
        {8'h00, 8'h00, 8'h00}
    };

    task automatic step();
        @(negedge phi2);
        #2;
    endtask

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [N-1:0] nxt(input logic [N-1:0] s, input logic [N-1:0] a,
                                         input logic [N-1:0] b);
        return (a & b) | (s & (a | b));
    endfunction

    task automatic capture(input logic [N-1:0] a, input logic [N-1:0] b);
        logic [N-1:0] old;
        old = state;
        in_a = a;
        in_b = b;
        #1;
        chk("R8 input change before phi1", state, old);
        #10;
        chk("R8 after phi1 only", state, old);
        step();
        chk("R7 capture next state", state, nxt(old, a, b));
    endtask

    initial begin
        logic [N-1:0] exp_s;
        logic [N-1:0] pat_p;
        logic [N-1:0] pat_q;
        pat_p = 8'hB5;
        pat_q = 8'h3A;

        step();
        chk("R9 reset state", state, '0);
        rst_n = 1'b1;

        // R1 R2 R3: table walk in transparent mode
        foreach (TV[k]) begin
            in_a = TV[k][3*N-1:2*N];
            in_b = TV[k][2*N-1:N];
            #1;
            chk("R1 R2 R3 transparent vector", state, TV[k][N-1:0]);
            step();
        end

        // R4: clocks and scan pins ignored while transparent
        in_a = 8'hFF; in_b = 8'hFF; #1;
        in_a = 8'hAA; in_b = 8'h55;
        scan_en = 1'b1;
        for (int k = 0; k < 3; k++) begin
            scan_in = k[0];
            step();
        end
        chk("R4 clocks ignored", state, 8'hFF);
        chk("R6 scan_out follows last cell", {7'd0, scan_out}, 8'h01);

        // R9: reset in transparent mode
        rst_n = 1'b0; #1;
        chk("R9 reset transparent", state, '0);
        step();
        rst_n = 1'b1;

        // R5: shift in pat_p, functional inputs set to all-set
        test_mode = 1'b1; scan_en = 1'b1;
        in_a = 8'hFF; in_b = 8'hFF;
        exp_s = '0;
        for (int k = 0; k < N; k++) begin
            scan_in = pat_p[N-1-k];
            step();
            exp_s = {exp_s[N-2:0], pat_p[N-1-k]};
            chk("R5 shift one place", state, exp_s);
        end
        chk("R6 word loaded", state, pat_p);

        // R6: shift out pat_p while shifting in pat_q
        for (int k = 0; k < N; k++) begin
            chk("R6 scan_out bit", {7'd0, scan_out}, {7'd0, pat_p[N-1-k]});
            scan_in = pat_q[N-1-k];
            step();
        end
        chk("R6 second word loaded", state, pat_q);

        // R7 R8: capture patterns mixing set, clear and hold lanes
        scan_en = 1'b0;
        capture(8'hF0, 8'hCC);
        capture(8'h0F, 8'h3C);
        capture(8'h55, 8'hAA);
        capture(8'h00, 8'h00);

        // R9: reset in shift mode after loading ones
        scan_en = 1'b1; scan_in = 1'b1;
        step(); step();
        rst_n = 1'b0; #1;
        chk("R9 reset shift mode", state, '0);
        #12;
        chk("R9 held through phases", state, '0);

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule